// File: doc/BRIEF.md
# Two-Step Converter Control Sequencer

This block is the digital controller of an 8-bit converter that resolves its result in two 4-bit steps. One comparator bank finds the upper nibble and a second bank finds the lower nibble. The analog comparators sit outside this block. It receives their outputs as two 15-bit thermometer codes and one overrange bit. It tells each bank when to compare and when to zero, and it counts its phase intervals from a clock. It decodes both codes, holds the 8-bit result in an output latch, and drives a data enable, an active-low interrupt, an open-drain busy pull-down and an always-driven overflow flag.

The host uses active-low select, write and read strobes. A strap input picks one of two handshakes. With the strap low, a read strobe alone starts the conversion, and the data is presented once both timed phases have run. With the strap high, the write strobe takes the sample. The host then either waits for the interrupt or reads early. An early read cuts the lower-bank phase short and latches the result at once. Every strobe passes through a two-flop synchronizer before its edges are detected.

Top module: `halfflash_seq`

## Requirements
- R1: After reset, irq_n=1, ovf_n=1, busy_drv=0, dout_en=0, hi_cmp=0, lo_cmp=0 and dout=0.
- R2: Edges on wr_n or rd_n while cs_n is high start no conversion, so hi_cmp stays 0 and irq_n is unchanged.
- R3: With mode_sel=1, a falling wr_n starts a conversion. While wr_n is low, hi_cmp=1 and lo_cmp=0. After wr_n rises, the upper nibble is captured, hi_cmp=0 and lo_cmp=1. The two phase outputs are never 1 together.
- R4: With mode_sel=1 and no read, the full result is latched and irq_n goes low T_INT cycles after the synchronized wr_n rise, plus synchronizer latency. irq_n never falls without a latch.
- R5: With mode_sel=1, a falling rd_n during the lower-bank phase latches the result within a few cycles and drives irq_n low. The lower nibble is the one present at that moment, and no second latch follows when the timeout would have expired.
- R6: With mode_sel=0, a falling rd_n starts the conversion. The upper bank compares for T_INT cycles, then the lower bank compares for T_INT cycles. The result is then latched and irq_n goes low.
- R7: With mode_sel=0, busy_drv goes to 1 after cs_n falls and returns to 0 when the result is latched.
- R8: irq_n returns to 1 after rd_n rises with cs_n low, or after cs_n rises.
- R9: dout_en is 1 only while cs_n and rd_n are both low, and never during the timed phases of a read-started conversion.
- R10: ovf_n shows the inverted overrange bit captured with the upper nibble. It changes only at a latch and stays driven while cs_n is high.
- R11: For T_REC cycles after a latch, start strobes are ignored. A start issued after that interval is accepted.
- R12: Each nibble is the number of 1 bits in its 15-bit thermometer code. dout[7:4] holds the upper nibble and dout[3:0] the lower. dout changes only at a latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| mode_sel | input | 1 | Strap: 0 read-started, 1 write-then-read; the pad pulls it low when left open |
| hi_therm | input | 15 | Upper-bank thermometer code |
| lo_therm | input | 15 | Lower-bank thermometer code |
| hi_over | input | 1 | Overrange comparator, 1 when the input exceeds the top reference |
| hi_cmp | output | 1 | Upper bank in compare (1) or zero (0) phase |
| lo_cmp | output | 1 | Lower bank in compare (1) or zero (0) phase |
| dout | output | 8 | Latched result |
| dout_en | output | 1 | Enable for the tri-state data pads |
| irq_n | output | 1 | Conversion-done interrupt, active low |
| busy_drv | output | 1 | 1 pulls the open-drain busy pad low, 0 leaves it floating |
| ovf_n | output | 1 | Overrange flag, active low, always driven |

## Verification
The hardest case to reach is an early read racing the internal timeout. The read must fall inside the lower-bank phase, after the write has risen and before T_INT expires. The lower-bank code must then change afterwards, so a second latch would be visible. The random loop draws the read delay across that window, and a directed case checks that the data stays put past the timeout. A start strobe placed a few cycles after a latch exercises the recovery lockout. The same strobe issued after the interval shows that it is accepted again.

// File: rtl/hfs_pkg.sv
package hfs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WSAMP = 3'd1,
    ST_LWAIT = 3'd2,
    ST_RHI   = 3'd3,
    ST_RLO   = 3'd4,
    ST_RECOV = 3'd5
  } seq_state_t;

  // upper bank compares while the input is being sampled
  function automatic logic upper_compare(input seq_state_t s);
    return (s == ST_WSAMP) || (s == ST_RHI);
  endfunction

  function automatic logic lower_compare(input seq_state_t s);
    return (s == ST_LWAIT) || (s == ST_RLO);
  endfunction

  // timed phases of a read-started conversion: data pads held off
  function automatic logic read_timed(input seq_state_t s);
    return (s == ST_RHI) || (s == ST_RLO);
  endfunction

endpackage

// File: rtl/hfs_sync.sv
module hfs_sync #(
  parameter int            W       = 1,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= {2{RST_VAL[i]}};
      else        sh <= {sh[0], d[i]};
    end
    assign q[i] = sh[1];
  end

endmodule

// File: rtl/hfs_therm_dec.sv
module hfs_therm_dec #(
  parameter int NIB_W = 4
) (
  input  logic [(1<<NIB_W)-2:0] therm,
  output logic [NIB_W-1:0]      nib
);

  localparam int TW = (1 << NIB_W) - 1;

  function automatic logic [NIB_W-1:0] ones_in(input logic [TW-1:0] v);
    logic [NIB_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < TW; i++) acc = acc + NIB_W'(v[i]);
    return acc;
  endfunction

  assign nib = ones_in(therm);

endmodule

// File: rtl/hfs_core.sv
module hfs_core
  import hfs_pkg::*;
#(
  parameter int NIB_W = 4,
  parameter int T_INT = 80,
  parameter int T_REC = 50
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_s,
  input  logic               wr_s,
  input  logic               rd_s,
  input  logic               mode_s,
  input  logic [NIB_W-1:0]   hi_nib,
  input  logic [NIB_W-1:0]   lo_nib,
  input  logic               over_in,
  output logic               hi_cmp,
  output logic               lo_cmp,
  output logic [2*NIB_W-1:0] dout,
  output logic               dout_en,
  output logic               irq_n,
  output logic               busy_drv,
  output logic               ovf_n,
  output logic               latch_evt,
  output logic               start_evt,
  output logic               rd_act,
  output logic               in_recov
);

  localparam int TMAX = (T_INT > T_REC) ? T_INT : T_REC;
  localparam int CW   = $clog2(TMAX + 1);
  localparam logic [CW-1:0] INT_LAST = CW'(T_INT - 1);
  localparam logic [CW-1:0] REC_LAST = CW'(T_REC - 1);

  seq_state_t state, nxt;
  logic [CW-1:0] cnt;
  logic cs_p, wr_p, rd_p;
  logic wr_act, wr_fall, wr_rise, rd_fall, rd_rise, cs_rise, cs_fall;
  logic hi_evt;
  logic [NIB_W-1:0] hi_q;
  logic over_q, ovf_q, irq_q, busy_q, en_q;
  logic [2*NIB_W-1:0] dout_q;

  // strobes count only under chip select
  assign wr_act  = !cs_s && !wr_s;
  assign rd_act  = !cs_s && !rd_s;
  assign wr_fall = wr_act && !wr_p;
  assign wr_rise = !wr_act && wr_p;
  assign rd_fall = rd_act && !rd_p;
  assign rd_rise = !rd_act && rd_p;
  assign cs_rise = cs_s && !cs_p;
  assign cs_fall = !cs_s && cs_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_p <= 1'b1;
      wr_p <= 1'b0;
      rd_p <= 1'b0;
    end else begin
      cs_p <= cs_s;
      wr_p <= wr_act;
      rd_p <= rd_act;
    end
  end

  always_comb begin
    nxt       = state;
    hi_evt    = 1'b0;
    latch_evt = 1'b0;
    start_evt = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (mode_s && wr_fall) begin
          nxt = ST_WSAMP; start_evt = 1'b1;
        end else if (!mode_s && rd_fall) begin
          nxt = ST_RHI; start_evt = 1'b1;
        end
      end
      ST_WSAMP: if (wr_rise) begin
        nxt = ST_LWAIT; hi_evt = 1'b1;
      end
      ST_LWAIT: if (rd_fall || cnt == INT_LAST) begin
        nxt = ST_RECOV; latch_evt = 1'b1;
      end
      ST_RHI: if (cnt == INT_LAST) begin
        nxt = ST_RLO; hi_evt = 1'b1;
      end
      ST_RLO: if (cnt == INT_LAST) begin
        nxt = ST_RECOV; latch_evt = 1'b1;
      end
      ST_RECOV: if (cnt == REC_LAST) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= nxt;
      if (nxt != state)          cnt <= '0;
      else if (state != ST_IDLE) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      over_q <= 1'b0;
      dout_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (hi_evt) begin
        hi_q   <= hi_nib;
        over_q <= over_in;
      end
      if (latch_evt) begin
        dout_q <= {hi_q, lo_nib};
        ovf_q  <= over_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b1;
      busy_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      if (latch_evt)               irq_q <= 1'b0;
      else if (rd_rise || cs_rise) irq_q <= 1'b1;
      if (latch_evt)               busy_q <= 1'b0;
      else if (cs_fall && !mode_s) busy_q <= 1'b1;
      en_q <= rd_act && !read_timed(nxt);
    end
  end

  assign hi_cmp   = upper_compare(state);
  assign lo_cmp   = lower_compare(state);
  assign in_recov = (state == ST_RECOV);
  assign dout     = dout_q;
  assign dout_en  = en_q;
  assign irq_n    = irq_q;
  assign busy_drv = busy_q;
  assign ovf_n    = !ovf_q;

endmodule

// File: rtl/halfflash_seq.sv
module halfflash_seq #(
  parameter int NIB_W = 4,
  parameter int T_INT = 80,
  parameter int T_REC = 50
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs_n,
  input  logic                    wr_n,
  input  logic                    rd_n,
  input  logic                    mode_sel,
  input  logic [(1<<NIB_W)-2:0]   hi_therm,
  input  logic [(1<<NIB_W)-2:0]   lo_therm,
  input  logic                    hi_over,
  output logic                    hi_cmp,
  output logic                    lo_cmp,
  output logic [2*NIB_W-1:0]      dout,
  output logic                    dout_en,
  output logic                    irq_n,
  output logic                    busy_drv,
  output logic                    ovf_n
);

  localparam int DW    = 2 * NIB_W;
  localparam int NSYNC = 4;

  logic [NSYNC-1:0] raw, synced;
  logic [NIB_W-1:0] hi_nib, lo_nib;
  logic latch_evt, start_evt, rd_act, in_recov, mode_s;

  assign raw = {mode_sel, rd_n, wr_n, cs_n};

  hfs_sync #(.W(NSYNC), .RST_VAL(4'b0111)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(synced)
  );

  assign mode_s = synced[3];

  hfs_therm_dec #(.NIB_W(NIB_W)) u_dec_hi (.therm(hi_therm), .nib(hi_nib));
  hfs_therm_dec #(.NIB_W(NIB_W)) u_dec_lo (.therm(lo_therm), .nib(lo_nib));

  hfs_core #(.NIB_W(NIB_W), .T_INT(T_INT), .T_REC(T_REC)) u_core (
    .clk(clk), .rst_n(rst_n),
    .cs_s(synced[0]), .wr_s(synced[1]), .rd_s(synced[2]), .mode_s(mode_s),
    .hi_nib(hi_nib), .lo_nib(lo_nib), .over_in(hi_over),
    .hi_cmp(hi_cmp), .lo_cmp(lo_cmp), .dout(dout), .dout_en(dout_en),
    .irq_n(irq_n), .busy_drv(busy_drv), .ovf_n(ovf_n),
    .latch_evt(latch_evt), .start_evt(start_evt), .rd_act(rd_act),
    .in_recov(in_recov)
  );

endmodule

// File: rtl/halfflash_seq_chk.sv
module halfflash_seq_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hi_cmp,
  input logic          lo_cmp,
  input logic          irq_n,
  input logic          ovf_n,
  input logic [DW-1:0] dout,
  input logic          dout_en,
  input logic          busy_drv,
  input logic          latch_evt,
  input logic          start_evt,
  input logic          rd_act,
  input logic          mode_s,
  input logic          in_recov
);

  p_phase_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_cmp && lo_cmp));

  p_start_cmp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> hi_cmp);

  p_irq_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> $past(latch_evt));

  p_latch_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    latch_evt |=> !irq_n);

  p_busy_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_drv) |-> $past(!mode_s));

  p_en_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> $past(rd_act));

  p_ovf_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(latch_evt) |-> $stable(ovf_n));

  p_recov_lock_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_recov |=> !hi_cmp);

  p_dout_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(latch_evt) |-> $stable(dout));

endmodule

bind halfflash_seq halfflash_seq_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .hi_cmp(hi_cmp), .lo_cmp(lo_cmp),
  .irq_n(irq_n), .ovf_n(ovf_n), .dout(dout), .dout_en(dout_en),
  .busy_drv(busy_drv), .latch_evt(latch_evt), .start_evt(start_evt),
  .rd_act(rd_act), .mode_s(mode_s), .in_recov(in_recov)
);

// File: tb/halfflash_seq_test.sv
`timescale 1ns/1ps
module halfflash_seq_test;

  localparam int TW    = 15;
  localparam int T_INT = 80;
  localparam int T_REC = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, mode_sel = 1'b0, hi_over = 1'b0;
  logic [TW-1:0] hi_therm = '0, lo_therm = '0;
  logic hi_cmp, lo_cmp, dout_en, irq_n, busy_drv, ovf_n;
  logic [7:0] dout;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  halfflash_seq #(.NIB_W(4), .T_INT(T_INT), .T_REC(T_REC)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .mode_sel(mode_sel), .hi_therm(hi_therm), .lo_therm(lo_therm),
    .hi_over(hi_over), .hi_cmp(hi_cmp), .lo_cmp(lo_cmp), .dout(dout),
    .dout_en(dout_en), .irq_n(irq_n), .busy_drv(busy_drv), .ovf_n(ovf_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [TW-1:0] mk_therm(input int k);
    logic [TW-1:0] v = '0;
    for (int i = 0; i < k; i++) v[i] = 1'b1;
    return v;
  endfunction

  // R12: nibble = population of the code, upper nibble in the high half
  function automatic int exp_byte(input int hk, input int lk);
    return ($countones(mk_therm(hk)) << 4) | $countones(mk_therm(lk));
  endfunction

  task automatic conv_wr(input int hk, input int lk, input bit ov,
                         input bit early, input int dly);
    int e;
    e = exp_byte(hk, lk);
    mode_sel = 1'b1;
    cs_n = 1'b0;
    hi_therm = mk_therm(hk);
    hi_over = ov;
    lo_therm = mk_therm(15 - lk);
    wr_n = 1'b0;
    wait_n(10);
    chk("R3 hi_cmp while write low", hi_cmp, 1);
    chk("R3 lo_cmp while write low", lo_cmp, 0);
    wr_n = 1'b1;
    wait_n(6);
    chk("R3 hi_cmp after write", hi_cmp, 0);
    chk("R3 lo_cmp after write", lo_cmp, 1);
    hi_therm = mk_therm(15 - hk);
    hi_over = !ov;
    lo_therm = mk_therm(lk);
    if (early) begin
      wait_n(dly);
      chk("R5 irq before early read", irq_n, 1);
      rd_n = 1'b0;
      wait_n(6);
      chk("R5 irq after early read", irq_n, 0);
      chk("R9 enable during read", dout_en, 1);
      chk("R5 early data", dout, e);
      chk("R10 overflow", ovf_n, !ov);
      lo_therm = mk_therm(15 - lk);
      wait_n(T_INT);
      chk("R5 no relatch at timeout", dout, e);
      rd_n = 1'b1;
      wait_n(6);
      chk("R8 irq after read rise", irq_n, 1);
    end else begin
      wait_n(T_INT - 12);
      chk("R4 irq before timeout", irq_n, 1);
      wait_n(14);
      chk("R4 irq after timeout", irq_n, 0);
      chk("R9 enable with read high", dout_en, 0);
      chk("R10 overflow", ovf_n, !ov);
      rd_n = 1'b0;
      wait_n(6);
      chk("R9 enable during read", dout_en, 1);
      chk("R12 data", dout, e);
      rd_n = 1'b1;
      wait_n(6);
      chk("R8 irq after read rise", irq_n, 1);
      chk("R9 enable after read", dout_en, 0);
    end
    wait_n(T_REC + 10);
  endtask

  task automatic conv_rd(input int hk, input int lk, input bit ov);
    int e;
    e = exp_byte(hk, lk);
    mode_sel = 1'b0;
    cs_n = 1'b1;
    wait_n(6);
    cs_n = 1'b0;
    wait_n(6);
    chk("R7 busy after select", busy_drv, 1);
    hi_therm = mk_therm(hk);
    lo_therm = mk_therm(lk);
    hi_over = ov;
    rd_n = 1'b0;
    wait_n(10);
    chk("R6 upper compare", hi_cmp, 1);
    chk("R9 enable held off", dout_en, 0);
    wait_n(T_INT);
    chk("R6 upper zeroing", hi_cmp, 0);
    chk("R6 lower compare", lo_cmp, 1);
    hi_therm = mk_therm(15 - hk);
    hi_over = !ov;
    wait_n(T_INT - 15);
    chk("R6 irq before end", irq_n, 1);
    chk("R7 busy before end", busy_drv, 1);
    wait_n(13);
    chk("R6 irq at end", irq_n, 0);
    chk("R7 busy released", busy_drv, 0);
    chk("R9 enable after end", dout_en, 1);
    chk("R6 data", dout, e);
    chk("R10 overflow", ovf_n, !ov);
    cs_n = 1'b1;
    wait_n(6);
    chk("R8 irq after select rise", irq_n, 1);
    chk("R9 enable select high", dout_en, 0);
    rd_n = 1'b1;
    wait_n(T_REC + 10);
  endtask

  initial begin
    #(10 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    wait_n(4);
    chk("R1 irq", irq_n, 1);
    chk("R1 ovf", ovf_n, 1);
    chk("R1 busy", busy_drv, 0);
    chk("R1 enable", dout_en, 0);
    chk("R1 hi_cmp", hi_cmp, 0);
    chk("R1 lo_cmp", lo_cmp, 0);
    chk("R1 dout", dout, 0);
    rst_n = 1'b1;
    wait_n(4);

    // R2: strobes without chip select
    mode_sel = 1'b1;
    wr_n = 1'b0;
    wait_n(10);
    chk("R2 write ignored", hi_cmp, 0);
    wr_n = 1'b1;
    rd_n = 1'b0;
    wait_n(10);
    chk("R2 read ignored enable", dout_en, 0);
    chk("R2 irq unchanged", irq_n, 1);
    rd_n = 1'b1;
    mode_sel = 1'b0;
    wait_n(4);
    rd_n = 1'b0;
    wait_n(10);
    chk("R2 read start ignored", hi_cmp, 0);
    rd_n = 1'b1;
    wait_n(T_INT * 2 + 10);
    chk("R2 no result", dout, 0);

    // directed corners
    conv_wr(15, 0, 1'b1, 1'b0, 0);
    cs_n = 1'b1;
    wait_n(6);
    chk("R10 overflow driven with select high", ovf_n, 0);
    conv_wr(0, 15, 1'b0, 1'b1, 60);
    conv_rd(9, 6, 1'b1);
    conv_rd(3, 12, 1'b0);

    // R11: start inside the recovery interval is ignored
    mode_sel = 1'b1;
    cs_n = 1'b0;
    hi_therm = mk_therm(5);
    lo_therm = mk_therm(7);
    wr_n = 1'b0;
    wait_n(8);
    wr_n = 1'b1;
    wait_n(20);
    rd_n = 1'b0;
    wait_n(6);
    chk("R5 latched", dout, exp_byte(5, 7));
    rd_n = 1'b1;
    wait_n(2);
    wr_n = 1'b0;
    wait_n(10);
    chk("R11 start locked out", hi_cmp, 0);
    wr_n = 1'b1;
    wait_n(6);
    chk("R11 lower idle", lo_cmp, 0);
    wait_n(T_REC + 10);
    wr_n = 1'b0;
    wait_n(8);
    chk("R11 start accepted later", hi_cmp, 1);
    wr_n = 1'b1;
    wait_n(T_INT + 10);
    rd_n = 1'b0;
    wait_n(6);
    chk("R12 data after recovery", dout, exp_byte(5, 7));
    rd_n = 1'b1;
    wait_n(T_REC + 10);

    // random mix of both modes
    for (int it = 0; it < 24; it++) begin
      int hk, lk, dly;
      bit ov, early, rdm;
      hk    = int'($urandom_range(15, 0));
      lk    = int'($urandom_range(15, 0));
      ov    = 1'($urandom_range(1, 0));
      early = 1'($urandom_range(1, 0));
      rdm   = ($urandom_range(3, 0) == 0);
      dly   = int'($urandom_range(60, 10));
      if (rdm) conv_rd(hk, lk, ov);
      else     conv_wr(hk, lk, ov, early, dly);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule